// File: doc/BRIEF.md
# Dual-Tone Period-Counting Detector

This block finds a keypad tone pair in two hard-limited square waves. One wave carries the low-frequency row tone and the other carries the high-frequency column tone. Each wave is synchronized to the system clock. The block counts clocks between successive rising edges and compares each period with an acceptance window around the four nominal periods of that group. The windows are computed when the design is elaborated, from the clock rate and a per-mille tolerance.

A group reports a tone only after a fixed number of consecutive periods all land in the window of the same tone. One period outside every window clears it at once, and so does a silence longer than the slowest period allowed. When both groups report a tone, the block raises a signal-present flag and registers the 4-bit key code of the pair. The code keeps its last value after the flag falls. An inhibit input masks the fourth column (the letter keys). A power-down input stops both period meters and holds the flag low.

Top module: `dtmf_pair_detector`

## Requirements
- R1: The 4-bit code follows the keypad layout. Rows are 697/770/852/941 Hz (index 0..3) and columns are 1209/1336/1477/1633 Hz (index 0..3). Keys 1..9 give 0001..1001, key 0 gives 1010, * gives 1011, # gives 1100, A/B/C give 1101/1110/1111, and D gives 0000.
- R2: A tone pair whose frequencies are each within ±1.5% of nominal raises the flag and presents the code of that pair.
- R3: If either tone is 4% or more away from every nominal tone of its group, the flag stays low.
- R4: One group alone, with the other wave silent, never raises the flag.
- R5: A group reports a tone only after AGREE_N consecutive measured periods in the same tone's window. The first rising edge after silence only starts the measurement. The flag is therefore still low half a low-group period before the AGREE_N-th measured low period ends, and high half a period after it ends.
- R6: A measured period that lies outside every window clears that group within a few clocks, and the flag falls.
- R7: If no rising edge arrives for longer than the slowest accepted period of the group, the group reports no tone and the flag falls.
- R8: While inhibit is high, pairs in column 3 (A, B, C, D) do not raise the flag and the code keeps its previous value. Other pairs are still detected.
- R9: While power-down is high, the flag is low from the next cycle on and the code is held. After release, the pair must qualify again from scratch.
- R10: After reset, the flag is low and the code is 0000.
- R11: The code changes only in a cycle where the flag is high. It keeps its value after the tones stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that the periods are counted in |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_sq_i | input | 1 | Hard-limited low-group square wave (asynchronous) |
| col_sq_i | input | 1 | Hard-limited high-group square wave (asynchronous) |
| pwdn_i | input | 1 | Power-down: stops detection and holds the flag low |
| inhibit_i | input | 1 | Masks the column-3 letter keys |
| sig_present_o | output | 1 | A valid pair is being received |
| code_o | output | 4 | Key code of the last pair that was accepted |

## Verification
The bench builds the detector with CLK_HZ = 200000, TOL_PPT = 25 and AGREE_N = 4. At this clock rate a 697 Hz period is about 287 clocks and a 1633 Hz period about 122 clocks. Every key, the ±1.5% accept and 4–6% reject deviations, dropouts and requalification after power-down therefore fit into a few thousand cycles per trial. A 2.5% window still spans several clock counts even for the shortest period, so rounding the bench's generated periods to whole clocks cannot move a tone across a window bound.

// File: rtl/dtmf_pkg.sv
`timescale 1ns/1ps
package dtmf_pkg;

  // nominal tone of a group: group 0 = rows, group 1 = columns
  function automatic int tone_hz(input int group, input int idx);
    int f;
    f = 0;
    if (group == 0) begin
      case (idx)
        0: f = 697;
        1: f = 770;
        2: f = 852;
        default: f = 941;
      endcase
    end else begin
      case (idx)
        0: f = 1209;
        1: f = 1336;
        2: f = 1477;
        default: f = 1633;
      endcase
    end
    return f;
  endfunction

  // shortest accepted period (tone fast by tol per mille)
  function automatic int per_lo(input longint clk_hz, input int f, input int tol);
    longint num, den;
    num = clk_hz * 1000;
    den = longint'(f) * longint'(1000 + tol);
    return int'(num / den);
  endfunction

  // longest accepted period (tone slow by tol per mille)
  function automatic int per_hi(input longint clk_hz, input int f, input int tol);
    longint num, den;
    num = clk_hz * 1000;
    den = longint'(f) * longint'(1000 - tol);
    return int'(num / den);
  endfunction

  // keypad code for a row/column pair
  function automatic logic [3:0] key_code(input logic [1:0] row, input logic [1:0] col);
    logic [3:0] c;
    if (col == 2'd3)       c = 4'd13 + {2'b00, row};   // letters; D wraps to 0
    else if (row == 2'd3)  c = (col == 2'd0) ? 4'd11 : (col == 2'd1) ? 4'd10 : 4'd12;
    else                   c = 4'(({2'b00, row} * 4'd3) + {2'b00, col} + 4'd1);
    return c;
  endfunction

endpackage

// File: rtl/dtmf_code_map.sv
`timescale 1ns/1ps
module dtmf_code_map (
  input  logic [1:0] row_i,
  input  logic [1:0] col_i,
  output logic [3:0] code_o
);
  import dtmf_pkg::*;

  always_comb begin
    code_o = key_code(row_i, col_i);
  end

endmodule

// File: rtl/dtmf_period_meter.sv
`timescale 1ns/1ps
module dtmf_period_meter #(
  parameter int GROUP   = 0,
  parameter int CLK_HZ  = 3579545,
  parameter int TOL_PPT = 25,
  parameter int AGREE_N = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       sq_i,
  output logic       tone_ok_o,
  output logic [1:0] tone_idx_o
);
  import dtmf_pkg::*;

  localparam int NTONE = 4;
  localparam int TMO   = per_hi(CLK_HZ, tone_hz(GROUP, 0), TOL_PPT) + 1;
  localparam int CW    = $clog2(TMO + 1);
  localparam int AW    = $clog2(AGREE_N + 1);

  logic [1:0]    sync_q, sync_n;
  logic          sq_q, sq_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          armed_q, armed_n;
  logic [AW-1:0] agree_q, agree_n;
  logic [1:0]    idx_q, idx_n;
  logic          ok_q, ok_n;
  logic [NTONE-1:0] hit;
  logic [1:0]    hit_idx;
  logic          rise_c, tmo_c;

  // one acceptance window per nominal tone
  genvar k;
  generate
    for (k = 0; k < NTONE; k++) begin : g_win
      localparam int LO = per_lo(CLK_HZ, tone_hz(GROUP, k), TOL_PPT);
      localparam int HI = per_hi(CLK_HZ, tone_hz(GROUP, k), TOL_PPT);
      assign hit[k] = (cnt_q >= CW'(LO)) && (cnt_q <= CW'(HI));
    end
  endgenerate

  always_comb begin
    hit_idx = 2'd0;
    for (int i = NTONE - 1; i >= 0; i--) begin
      if (hit[i]) hit_idx = 2'(i);
    end
  end

  assign rise_c = sync_q[1] & ~sq_q;
  assign tmo_c  = armed_q && (cnt_q == CW'(TMO));

  always_comb begin
    sync_n  = {sync_q[0], sq_i};
    sq_n    = sync_q[1];
    cnt_n   = cnt_q;
    armed_n = armed_q;
    agree_n = agree_q;
    idx_n   = idx_q;
    ok_n    = ok_q;
    if (!en) begin
      cnt_n   = '0;
      armed_n = 1'b0;
      agree_n = '0;
      ok_n    = 1'b0;
    end else if (rise_c) begin
      cnt_n   = CW'(1);
      armed_n = 1'b1;
      if (armed_q && (|hit)) begin
        if ((agree_q != '0) && (hit_idx == idx_q)) begin
          agree_n = (agree_q == AW'(AGREE_N)) ? agree_q : agree_q + AW'(1);
        end else begin
          agree_n = AW'(1);
        end
        idx_n = hit_idx;
      end else begin
        agree_n = '0;
      end
      ok_n = (agree_n == AW'(AGREE_N));
    end else if (tmo_c) begin
      cnt_n   = '0;
      armed_n = 1'b0;
      agree_n = '0;
      ok_n    = 1'b0;
    end else if (armed_q) begin
      cnt_n = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      sq_q    <= 1'b0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      agree_q <= '0;
      idx_q   <= '0;
      ok_q    <= 1'b0;
    end else begin
      sync_q  <= sync_n;
      sq_q    <= sq_n;
      cnt_q   <= cnt_n;
      armed_q <= armed_n;
      agree_q <= agree_n;
      idx_q   <= idx_n;
      ok_q    <= ok_n;
    end
  end

  assign tone_ok_o  = ok_q;
  assign tone_idx_o = idx_q;

  // R5: a tone is declared only at a measured edge
  a_r5_ok_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_ok_o) |-> $past(rise_c && en));

  // R6: an out-of-window period clears the group
  a_r6_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rise_c && armed_q && !(|hit)) |=> !tone_ok_o);

  // R7: silence beyond the slowest period clears the group
  a_r7_timeout_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tmo_c) |=> !tone_ok_o);

endmodule

// File: rtl/dtmf_pair_detector.sv
`timescale 1ns/1ps
module dtmf_pair_detector #(
  parameter int CLK_HZ  = 3579545,
  parameter int TOL_PPT = 25,
  parameter int AGREE_N = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       row_sq_i,
  input  logic       col_sq_i,
  input  logic       pwdn_i,
  input  logic       inhibit_i,
  output logic       sig_present_o,
  output logic [3:0] code_o
);

  localparam logic [1:0] LETTER_COL = 2'd3;

  logic       run;
  logic       row_ok, col_ok;
  logic [1:0] row_idx, col_idx;
  logic [3:0] pair_code;
  logic       flag_q, flag_n;
  logic [3:0] code_q, code_n;

  assign run = ~pwdn_i;

  dtmf_period_meter #(.GROUP(0), .CLK_HZ(CLK_HZ), .TOL_PPT(TOL_PPT), .AGREE_N(AGREE_N)) u_row (
    .clk(clk), .rst_n(rst_n), .en(run), .sq_i(row_sq_i),
    .tone_ok_o(row_ok), .tone_idx_o(row_idx));

  dtmf_period_meter #(.GROUP(1), .CLK_HZ(CLK_HZ), .TOL_PPT(TOL_PPT), .AGREE_N(AGREE_N)) u_col (
    .clk(clk), .rst_n(rst_n), .en(run), .sq_i(col_sq_i),
    .tone_ok_o(col_ok), .tone_idx_o(col_idx));

  dtmf_code_map u_map (.row_i(row_idx), .col_i(col_idx), .code_o(pair_code));

  always_comb begin
    flag_n = run && row_ok && col_ok && !(inhibit_i && (col_idx == LETTER_COL));
    code_n = flag_n ? pair_code : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      code_q <= 4'd0;
    end else begin
      flag_q <= flag_n;
      code_q <= code_n;
    end
  end

  assign sig_present_o = flag_q;
  assign code_o        = code_q;

  // R4: flag needs both groups
  a_r4_both_groups: assert property (@(posedge clk) disable iff (!rst_n)
    sig_present_o |-> $past(row_ok && col_ok));

  // R8: inhibited letter column never flags
  a_r8_inhibit_letters: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_present_o && $past(inhibit_i)) |-> ($past(col_idx) != LETTER_COL));

  // R9: power-down forces the flag low
  a_r9_pwdn_low: assert property (@(posedge clk) disable iff (!rst_n)
    pwdn_i |=> !sig_present_o);

  // R11: code moves only together with the flag
  a_r11_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_o) |-> sig_present_o);

endmodule

// File: tb/sim_dtmf_pair_detector.sv
`timescale 1ns/1ps
module sim_dtmf_pair_detector;

  localparam int CLK_HZ = 200000;
  localparam int AGREE  = 4;

  logic clk, rst_n, row_sq, col_sq, pwdn, inhibit;
  logic sig;
  logic [3:0] code;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int row_per = 0, col_per = 0;
  bit row_rst = 0, col_rst = 0;
  int row_ctr = 0, col_ctr = 0;

  dtmf_pair_detector #(.CLK_HZ(CLK_HZ), .TOL_PPT(25), .AGREE_N(AGREE)) u0 (
    .clk(clk), .rst_n(rst_n), .row_sq_i(row_sq), .col_sq_i(col_sq),
    .pwdn_i(pwdn), .inhibit_i(inhibit), .sig_present_o(sig), .code_o(code));

  initial begin
    clk = 0;
    forever #10 clk = ~clk;
  end

  // square-wave generators, updated on falling edges
  initial begin
    row_sq = 0;
    col_sq = 0;
    forever begin
      @(negedge clk);
      if (row_rst) begin row_ctr = 0; row_rst = 0; end
      else if (row_per != 0) row_ctr = (row_ctr + 1 >= row_per) ? 0 : row_ctr + 1;
      row_sq = (row_per != 0) && (row_ctr < row_per / 2);
      if (col_rst) begin col_ctr = 0; col_rst = 0; end
      else if (col_per != 0) col_ctr = (col_ctr + 1 >= col_per) ? 0 : col_ctr + 1;
      col_sq = (col_per != 0) && (col_ctr < col_per / 2);
    end
  end

  function automatic int row_hz(input int r);
    int t[4] = '{697, 770, 852, 941};
    return t[r];
  endfunction

  function automatic int col_hz(input int c);
    int t[4] = '{1209, 1336, 1477, 1633};
    return t[c];
  endfunction

  // period in clocks of a tone off nominal by dev per mille
  function automatic int per_of(input int f, input int dev);
    longint den;
    den = longint'(f) * longint'(1000 + dev);
    return int'((longint'(CLK_HZ) * 1000 + den / 2) / den);
  endfunction

  // R1 keypad codes, written per key
  function automatic int exp_code(input int r, input int c);
    case ({r[1:0], c[1:0]})
      4'b0000: return 1;  4'b0001: return 2;  4'b0010: return 3;  4'b0011: return 13;
      4'b0100: return 4;  4'b0101: return 5;  4'b0110: return 6;  4'b0111: return 14;
      4'b1000: return 7;  4'b1001: return 8;  4'b1010: return 9;  4'b1011: return 15;
      4'b1100: return 11; 4'b1101: return 10; 4'b1110: return 12; default: return 0;
    endcase
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tones(input int rp, input int cp);
    row_per = rp; col_per = cp;
    row_rst = 1;  col_rst = 1;
  endtask

  task automatic silence();
    row_per = 0; col_per = 0;
    step(800);
  endtask

  initial begin
    int last;
    int seed;
    seed = $urandom(32'd2024);
    rst_n = 0; pwdn = 0; inhibit = 0;
    step(4);
    chk("R10 flag after reset", int'(sig), 0);
    chk("R10 code after reset", int'(code), 0);
    rst_n = 1;
    step(10);

    // R5: qualification timing on key 5
    begin
      int rp;
      rp = per_of(770, 0);
      tones(rp, per_of(1336, 0));
      step(AGREE * rp - rp / 2);
      chk("R5 flag before 4th period", int'(sig), 0);
      step(rp);
      chk("R5 flag after 4th period", int'(sig), 1);
      chk("R1 code key 5", int'(code), 5);
    end
    last = 5;

    // R7/R11: tones stop
    silence();
    chk("R7 flag after silence", int'(sig), 0);
    chk("R11 code held", int'(code), last);

    // R4: row tone alone
    tones(per_of(852, 0), 0);
    step(2500);
    chk("R4 row alone", int'(sig), 0);
    silence();
    tones(0, per_of(1209, 0));
    step(2500);
    chk("R4 column alone", int'(sig), 0);
    silence();

    // R6: column drifts off window mid-tone
    begin
      int cp;
      tones(per_of(941, 0), per_of(1477, 0));
      step(2500);
      chk("R2 key # flag", int'(sig), 1);
      chk("R1 code key #", int'(code), 12);
      last = 12;
      cp = per_of(1477, 50);
      col_per = cp;
      step(3 * cp + 10);
      chk("R6 flag after off-window period", int'(sig), 0);
      chk("R11 code after drop", int'(code), last);
      silence();
    end

    // R9: power-down
    tones(per_of(852, 0), per_of(1477, 0));
    step(2500);
    chk("R2 key 9 flag", int'(sig), 1);
    last = 9;
    pwdn = 1;
    step(2);
    chk("R9 flag at power-down", int'(sig), 0);
    step(2000);
    chk("R9 flag held low", int'(sig), 0);
    chk("R9 code held", int'(code), last);
    pwdn = 0;
    step(3);
    chk("R9 no flag right after release", int'(sig), 0);
    step(2500);
    chk("R9 requalified", int'(sig), 1);
    silence();

    // R8: inhibit of letter column
    inhibit = 1;
    tones(per_of(852, 0), per_of(1633, 0));
    step(2500);
    chk("R8 key C inhibited", int'(sig), 0);
    chk("R8 code kept", int'(code), last);
    silence();
    tones(per_of(697, 0), per_of(1209, 0));
    step(2500);
    chk("R8 digit under inhibit", int'(sig), 1);
    chk("R8 code key 1", int'(code), 1);
    silence();
    inhibit = 0;
    tones(per_of(941, 0), per_of(1633, 0));
    step(2500);
    chk("R1 key D flag", int'(sig), 1);
    chk("R1 code key D", int'(code), 0);
    last = 0;
    silence();

    // random trials: R2 accept, R3 reject
    for (int t = 0; t < 20; t++) begin
      int r, c, dr, dc, rej;
      r = int'($urandom % 4);
      c = int'($urandom % 4);
      dr = int'($urandom % 31) - 15;
      dc = int'($urandom % 31) - 15;
      rej = int'($urandom % 3);
      if (rej == 1) dr = ((($urandom % 2) == 0) ? 1 : -1) * (40 + int'($urandom % 21));
      if (rej == 2) dc = ((($urandom % 2) == 0) ? 1 : -1) * (40 + int'($urandom % 21));
      tones(per_of(row_hz(r), dr), per_of(col_hz(c), dc));
      step(2500);
      if (rej == 0) begin
        chk("R2 random accept flag", int'(sig), 1);
        chk("R1 random code", int'(code), exp_code(r, c));
        last = exp_code(r, c);
      end else begin
        chk("R3 random reject flag", int'(sig), 0);
        chk("R3 code unchanged", int'(code), last);
      end
      silence();
      chk("R7 random silence", int'(sig), 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule